// File: doc/BRIEF.md
# Stereo Serial Audio Input Register

This block takes in a stream of stereo audio samples on three lines: a bit clock, a serial data line and a word-select line. Left and right samples share the data line and take turns on it. Each sample arrives with its most significant bit first. The level of word-select tells the block which channel the current word belongs to.

When word-select changes level, the word that was being shifted in is finished. The block stores it in the left or the right input register, according to the level word-select had while that word arrived. Once a right word is finished, the block copies both input registers into a second rank of output registers on a single clock edge. The output registers drive the converter's bit switches, so the left and right switch codes always change together. A strobe that lasts one clock marks each of these updates.

Samples are W-bit two's complement words, so the value zero is the mid-scale code. The bit clock also serves as the block clock.

Top module: `stereo_word_rx`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, the block takes the following state: `left_q` and `right_q` are all zeros (the mid-scale code) and `upd` is low. Any partial word and both input registers are cleared as well.
- R2: `sdata` and `wsel` are sampled on the rising edge of `clk`. The bit sampled together with a new `wsel` level becomes bit W-1 of the new word. Each later bit of that word lands one position lower.
- R3: A word sent while `wsel` is 1 is stored as the left sample.
- R4: A word sent while `wsel` is 0 is stored as the right sample.
- R5: The right word is finished at the edge where `wsel` is first sampled 1 after being 0. One edge after that, `left_q` and `right_q` both take the stored left and right words, and `upd` is high for exactly that one cycle.
- R6: `left_q` and `right_q` change only in a cycle where `upd` is high, or through reset.
- R7: Bits past the first W of a word are ignored.
- R8: A word shorter than W bits has its missing low bits filled with zeros.
- R9: After reset, data that arrives before the first change of `wsel` is discarded and causes no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdata | input | 1 | Serial sample data, most significant bit first |
| wsel | input | 1 | Channel select: 1 marks a left word, 0 marks a right word |
| left_q | output | W | Left switch code from the output rank |
| right_q | output | W | Right switch code from the output rank |
| upd | output | 1 | One-cycle strobe, high in the cycle the output rank takes new codes |

## Verification
The bench builds the block with W = 16. At this width, words cut to a single bit, words of 9 bits, words stretched to 20 or 24 bits and full words can all be sent in frames of a few dozen cycles. This covers zero fill, dropped trailing bits and the extreme codes 8000h, 7FFFh, FFFFh and 0001h. A scoreboard predicts each stereo pair. Every update is checked against that prediction, including the first frame after reset (which follows leading garbage) and the first frame after a reset in the middle of the stream.

// File: rtl/stereo_word_rx.sv
module stereo_word_rx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sdata,
  input  logic         wsel,
  output logic [W-1:0] left_q,
  output logic [W-1:0] right_q,
  output logic         upd
);
  localparam int CW = $clog2(W + 1);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic          ws_prev, armed, xfer;
  logic [CW-1:0] cnt;
  logic [IW-1:0] pos;
  logic [W-1:0]  acc, left_in, right_in;

  wire ws_edge = wsel ^ ws_prev;
  wire commit  = ws_edge & armed;
  wire room    = cnt < CW'(W);

  assign pos = IW'(W - 1) - IW'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_prev  <= 1'b0;
      armed    <= 1'b0;
      xfer     <= 1'b0;
      cnt      <= '0;
      acc      <= '0;
      left_in  <= '0;
      right_in <= '0;
      left_q   <= '0;
      right_q  <= '0;
      upd      <= 1'b0;
    end else begin
      ws_prev <= wsel;
      xfer    <= commit & ~ws_prev;
      upd     <= xfer;
      if (ws_edge) begin
        armed <= 1'b1;
        acc   <= {sdata, {(W-1){1'b0}}};
        cnt   <= CW'(1);
      end else if (room) begin
        acc[pos] <= sdata;
        cnt      <= cnt + CW'(1);
      end
      if (commit &  ws_prev) left_in  <= acc;
      if (commit & ~ws_prev) right_in <= acc;
      if (xfer) begin
        left_q  <= left_in;
        right_q <= right_in;
      end
    end
  end
endmodule

module stereo_word_rx_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         sdata,
  input logic         wsel,
  input logic [W-1:0] left_q,
  input logic [W-1:0] right_q,
  input logic         upd
);
  p_reset_mid_r1: assert property (@(posedge clk)
    rst |=> (left_q == '0 && right_q == '0 && !upd));

  p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
    !upd |-> ($stable(left_q) && $stable(right_q)));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    upd |=> !upd);

  p_after_right_r5: assert property (@(posedge clk) disable iff (rst)
    upd |-> ($past(wsel, 2) && !$past(wsel, 3)));

  p_no_edge_no_upd_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(wsel, 2) == $past(wsel, 3)) |-> !upd);
endmodule

bind stereo_word_rx stereo_word_rx_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .sdata(sdata), .wsel(wsel),
  .left_q(left_q), .right_q(right_q), .upd(upd)
);

// File: tb/stereo_word_rx_tb.sv
module stereo_word_rx_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdata = 1'b0;
  logic wsel = 1'b0;
  logic [W-1:0] left_q, right_q;
  logic upd;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [W-1:0] q_l[$];
  logic [W-1:0] q_r[$];
  string        q_tag[$];

  always #2 clk = ~clk;

  stereo_word_rx #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .sdata(sdata), .wsel(wsel),
    .left_q(left_q), .right_q(right_q), .upd(upd)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      summary();
    end
  end

  // monitor: compare each update against the predicted pair
  always @(negedge clk) begin
    if (!rst && upd) begin
      if (q_l.size() == 0) begin
        check(1'b0, "R5/R9 unexpected upd", left_q, '0);
      end else begin
        automatic logic [W-1:0] el = q_l.pop_front();
        automatic logic [W-1:0] er = q_r.pop_front();
        automatic string t = q_tag.pop_front();
        check(left_q == el, {t, " R3 R5 left"}, left_q, el);
        check(right_q == er, {t, " R4 R5 right"}, right_q, er);
      end
    end
  end

  function automatic logic [W-1:0] expect_word(input logic [W-1:0] v, input int n);
    logic [W-1:0] m;
    m = '1;
    if (n < W) m = ~((W'(1) << (W - n)) - W'(1));
    return v & m;
  endfunction

  task automatic send_word(input bit ws, input logic [W-1:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wsel  = ws;
      sdata = (i < W) ? v[W-1-i] : i[0];
    end
  endtask

  task automatic send_frame(input logic [W-1:0] l, input int nl,
                            input logic [W-1:0] r, input int nr, input string tag);
    q_l.push_back(expect_word(l, nl));
    q_r.push_back(expect_word(r, nr));
    q_tag.push_back(tag);
    send_word(1'b1, l, nl);
    send_word(1'b0, r, nr);
  endtask

  task automatic close_and_wait();
    send_word(1'b1, 16'h0F0F, 3);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(left_q == '0 && right_q == '0, "R1 reset left/right", left_q, '0);
    check(upd == 1'b0, "R1 reset upd", {{(W-1){1'b0}}, upd}, '0);
    rst = 1'b0;
    // R9: garbage while wsel stays low after reset
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      wsel = 1'b0;
      sdata = 1'b1;
    end
    send_frame(16'hA5C3, 16, 16'h1234, 16, "R2 R9 first");
    send_frame(16'h8000, 16, 16'h7FFF, 16, "R2 extremes");
    send_frame(16'hFFFF, 16, 16'h0001, 16, "R2 ones");
    send_frame(16'h5A3C, 20, 16'hC001, 16, "R7 long left");
    send_frame(16'h0FF0, 16, 16'hBEEF, 9, "R8 short right");
    send_frame(16'h8000, 1, 16'h6789, 24, "R7 R8 mixed");
    close_and_wait();
    check(q_l.size() == 0, "R5 all frames updated", W'(q_l.size()), '0);
    // R6/R7: a long left word with no close must not move the outputs
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      wsel = 1'b1;
      sdata = i[1];
    end
    check(left_q == 16'h8000, "R6 hold left", left_q, 16'h8000);
    check(right_q == 16'h6789, "R6 hold right", right_q, 16'h6789);
    // R1: reset in the middle of the stream
    send_word(1'b0, 16'hAAAA, 5);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(left_q == '0 && right_q == '0, "R1 mid reset data", right_q, '0);
    check(upd == 1'b0, "R1 mid reset upd", {{(W-1){1'b0}}, upd}, '0);
    rst = 1'b0;
    wsel = 1'b0;
    send_frame(16'h1357, 16, 16'h2468, 16, "R1 R9 after reset");
    close_and_wait();
    check(q_l.size() == 0, "R5 post reset update", W'(q_l.size()), '0);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule